// File: doc/BRIEF.md
# Forced Chip-Select Output Controller

This block owns a small group of output lines, six by default, that are normally wired to the chip-select inputs of serial peripherals. A configuration word marks which lines serve as chip selects and which lines are inverted. A separate command word moves each line to its high or low internal level. Each line has its own "set" bit and its own "clear" bit in that word. A driver can therefore select or release one device in a single write, without reading the register back first.

The level at the pin is the internal level exclusive-ORed with that line's invert bit. With the invert bit at 0, an active-low device is selected by clearing its line. An active-high device is served by setting the invert bit. A status word reports the internal levels. After reset every line sits at its set level, so no active-low device is selected.

Top module: `csctl_top`

## Requirements
- R1: After reset the configuration word is 0, every internal level is 1, every pin is 1, every chip-select mark is 0 and the status word reads all ones in bits NUM_LINES-1:0.
- R2: A command write with bit 8+n at 1 and bit n at 0 makes internal level n equal 1 from the next clock edge on.
- R3: A command write with bit n at 1 and bit 8+n at 0 makes internal level n equal 0 from the next clock edge on.
- R4: A command write with bits n and 8+n both at 1 leaves internal level n unchanged.
- R5: A line whose bits n and 8+n are both 0 in a command write, or any line in a cycle without a command write, keeps its internal level.
- R6: Pin n always equals internal level n XOR bit n of the most recently written configuration word.
- R7: Output csMark[n] equals bit 8+n of the most recently written configuration word. A line with csMark[n] at 0 still follows its command bits as a general-purpose output.
- R8: statusOut bits NUM_LINES-1:0 carry the internal levels and all higher bits read 0. A configuration write never changes the status word.
- R9: Writing the command value 0xFF00 drives every line to internal level 1.
- R10: The default build has NUM_LINES = 6. A reduced build with NUM_LINES = 3 uses the same field positions. Command bits that belong to no line have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the configuration word |
| cfgWrData | input | 16 | Configuration word: bit n inverts line n, bit 8+n marks line n as a chip select |
| cmdWrEn | input | 1 | Write strobe for the command word |
| cmdWrData | input | 16 | Command word: bit 8+n sets line n, bit n clears line n |
| csPin | output | NUM_LINES | Pin levels after inversion |
| csMark | output | NUM_LINES | Chip-select role of each line |
| statusOut | output | 16 | Internal levels in bits NUM_LINES-1:0, zero above |

## Verification
The properties are evaluated on every clock cycle. They cover the per-line set, clear, conflict and hold rules, the fact that the pins follow the internal levels through the invert bits, and the zero upper bits of the status word. Several behaviours can only be shown by the bench scenarios: the reset values, the all-lines release by 0xFF00, lines that have no chip-select mark still switching, and long mixed runs of configuration and command writes. The bench compares those runs against a model of the register rules.

// File: rtl/csctl_pkg.sv
package csctl_pkg;
  localparam int WORD_W    = 16;
  localparam int MAX_LINES = 8;
  localparam int SET_BASE  = 8;

  // strobes passed from control to datapath in one cycle
  typedef struct packed {
    logic                 cfgLoad;
    logic [WORD_W-1:0]    cfgWord;
    logic [MAX_LINES-1:0] setMask;
    logic [MAX_LINES-1:0] clrMask;
  } ctlStrobe_t;
endpackage

// File: rtl/csctl_ctrl.sv
module csctl_ctrl
  import csctl_pkg::*;
#(
  parameter int NUM_LINES = 6
) (
  input  logic              cfgWrEn,
  input  logic [WORD_W-1:0] cfgWrData,
  input  logic              cmdWrEn,
  input  logic [WORD_W-1:0] cmdWrData,
  output ctlStrobe_t        strobe
);
  logic [MAX_LINES-1:0] setBits;
  logic [MAX_LINES-1:0] clrBits;

  assign setBits = cmdWrData[SET_BASE +: MAX_LINES];
  assign clrBits = cmdWrData[0 +: MAX_LINES];

  always_comb begin
    strobe         = '0;
    strobe.cfgLoad = cfgWrEn;
    strobe.cfgWord = cfgWrData;
    for (int i = 0; i < MAX_LINES; i++) begin
      if (i < NUM_LINES && cmdWrEn) begin
        // a set and a clear together cancel out
        strobe.setMask[i] = setBits[i] & ~clrBits[i];
        strobe.clrMask[i] = clrBits[i] & ~setBits[i];
      end
    end
  end
endmodule

// File: rtl/csctl_dp.sv
module csctl_dp
  import csctl_pkg::*;
#(
  parameter int NUM_LINES = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  output logic [NUM_LINES-1:0] csPin,
  output logic [NUM_LINES-1:0] csMark,
  output logic [NUM_LINES-1:0] levelOut
);
  logic [NUM_LINES-1:0] invReg;
  logic [NUM_LINES-1:0] markReg;
  logic [NUM_LINES-1:0] levelReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      invReg  <= '0;
      markReg <= '0;
    end else if (strobe.cfgLoad) begin
      invReg  <= strobe.cfgWord[0 +: NUM_LINES];
      markReg <= strobe.cfgWord[SET_BASE +: NUM_LINES];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  levelReg[g] <= 1'b1;
      else if (strobe.setMask[g]) levelReg[g] <= 1'b1;
      else if (strobe.clrMask[g]) levelReg[g] <= 1'b0;
    end
    assign csPin[g] = levelReg[g] ^ invReg[g];
  end

  assign csMark   = markReg;
  assign levelOut = levelReg;
endmodule

// File: rtl/csctl_top.sv
module csctl_top
  import csctl_pkg::*;
#(
  parameter int NUM_LINES = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [15:0]          cfgWrData,
  input  logic                 cmdWrEn,
  input  logic [15:0]          cmdWrData,
  output logic [NUM_LINES-1:0] csPin,
  output logic [NUM_LINES-1:0] csMark,
  output logic [15:0]          statusOut
);
  ctlStrobe_t           strobe;
  logic [NUM_LINES-1:0] levelOut;

  csctl_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .strobe(strobe)
  );

  csctl_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .csPin(csPin), .csMark(csMark), .levelOut(levelOut)
  );

  always_comb begin
    statusOut = '0;
    statusOut[NUM_LINES-1:0] = levelOut;
  end
endmodule

// File: rtl/csctl_checker.sv
module csctl_checker #(
  parameter int NUM_LINES = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgWrEn,
  input logic [15:0]          cfgWrData,
  input logic                 cmdWrEn,
  input logic [15:0]          cmdWrData,
  input logic [NUM_LINES-1:0] csPin,
  input logic [NUM_LINES-1:0] csMark,
  input logic [15:0]          statusOut
);
  logic [NUM_LINES-1:0] shadowInv;
  logic [NUM_LINES-1:0] shadowMark;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowInv  <= '0;
      shadowMark <= '0;
    end else if (cfgWrEn) begin
      shadowInv  <= cfgWrData[NUM_LINES-1:0];
      shadowMark <= cfgWrData[8 +: NUM_LINES];
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : gChk
    a_r2_set_line: assert property (@(posedge clk) disable iff (!rstN)
      cmdWrEn && cmdWrData[8+i] && !cmdWrData[i] |=> statusOut[i]);
    a_r3_clear_line: assert property (@(posedge clk) disable iff (!rstN)
      cmdWrEn && cmdWrData[i] && !cmdWrData[8+i] |=> !statusOut[i]);
    a_r4_conflict_hold: assert property (@(posedge clk) disable iff (!rstN)
      cmdWrEn && cmdWrData[i] && cmdWrData[8+i] |=> $stable(statusOut[i]));
    a_r6_pin_level: assert property (@(posedge clk) disable iff (!rstN)
      csPin[i] == (statusOut[i] ^ shadowInv[i]));
  end

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWrEn |=> $stable(statusOut));
  a_r7_mark_follows: assert property (@(posedge clk) disable iff (!rstN)
    csMark == shadowMark);
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut >> NUM_LINES) == 16'd0);
endmodule

bind csctl_top csctl_checker #(.NUM_LINES(NUM_LINES)) u_checker (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData), .csPin(csPin),
  .csMark(csMark), .statusOut(statusOut)
);

// File: tb/csctl_top_bench.sv
`timescale 1ns/1ps
module csctl_top_bench;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWrEn = 1'b0;
  logic [15:0]  cfgWrData = '0;
  logic         cmdWrEn = 1'b0;
  logic [15:0]  cmdWrData = '0;
  logic [N-1:0] csPin;
  logic [N-1:0] csMark;
  logic [15:0]  statusOut;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] expLevel, expInv, expMark;

  always #2.5 clk = ~clk;

  csctl_top #(.NUM_LINES(N)) u_csctl_top (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData), .csPin(csPin),
    .csMark(csMark), .statusOut(statusOut)
  );

  function automatic logic [N-1:0] applyCmd(logic [N-1:0] lv, logic [15:0] cmd);
    logic [N-1:0] r = lv;
    for (int i = 0; i < N; i++) begin
      if (cmd[8+i] && !cmd[i]) r[i] = 1'b1;
      else if (cmd[i] && !cmd[8+i]) r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [15:0] expStatus(logic [N-1:0] lv);
    logic [15:0] s = '0;
    s[N-1:0] = lv;
    return s;
  endfunction

  task automatic checkAll(string tag);
    checks++;
    if (statusOut !== expStatus(expLevel) || csPin !== (expLevel ^ expInv)
        || csMark !== expMark) begin
      errors++;
      $display("FAIL %s status=%h/%h pin=%b/%b mark=%b/%b (actual/expected)",
               tag, statusOut, expStatus(expLevel), csPin, expLevel ^ expInv,
               csMark, expMark);
    end
  endtask

  task automatic writeRegs(bit doCfg, logic [15:0] cfg, bit doCmd, logic [15:0] cmd);
    @(negedge clk);
    cfgWrEn = doCfg; cfgWrData = cfg;
    cmdWrEn = doCmd; cmdWrData = cmd;
    @(negedge clk);
    cfgWrEn = 1'b0; cmdWrEn = 1'b0;
    if (doCmd) expLevel = applyCmd(expLevel, cmd);
    if (doCfg) begin
      expInv  = cfg[N-1:0];
      expMark = cfg[8 +: N];
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    expLevel = '1; expInv = '0; expMark = '0;
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");

    writeRegs(0, '0, 1, 16'h0001); checkAll("R3 clear line0");
    writeRegs(0, '0, 1, 16'h0100); checkAll("R2 set line0");
    writeRegs(0, '0, 1, 16'h003F); checkAll("R3 clear all");
    writeRegs(0, '0, 1, 16'h0909); checkAll("R4 conflict lines0,3");
    writeRegs(0, '0, 1, 16'h0000); checkAll("R5 empty command");
    writeRegs(0, '0, 0, 16'h3F00); checkAll("R5 no strobe");
    writeRegs(0, '0, 1, 16'hFF00); checkAll("R9 release all");
    writeRegs(1, 16'h0305, 0, '0); checkAll("R6 invert pins R8 status unchanged");
    writeRegs(0, '0, 1, 16'h0024); checkAll("R7 unmarked lines follow");
    writeRegs(0, '0, 1, 16'hC0C0); checkAll("R10 unused bits ignored");
    writeRegs(1, 16'h3F3F, 1, 16'h0012); checkAll("R6 R7 cfg and cmd together");

    for (int k = 0; k < 400; k++) begin
      logic [15:0] c = 16'($urandom);
      logic [15:0] m = 16'($urandom);
      writeRegs(1'($urandom), c, 1'($urandom), m);
      checkAll("R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule